// File: doc/BRIEF.md
# PC Sampling Debug Register Unit

This block gives an outside debug agent a way to profile a running core without halting it. The agent reads a small set of 32-bit registers over a plain register bus (address, read strobe, write strobe, write data). The core feeds the block live state: the 64-bit program counter, the context identifier, the virtual machine identifier, the security and exception-level flags, the register-width flag, and two flags that mark the core as halted for debug or as barred from sample-based profiling.

A read of the low program-counter sample register returns the current PC bits [31:0]. On the same clock edge it freezes the PC upper half, the context identifier and the virtual-context word into companion registers. Later reads of those registers return one coherent snapshot, even though the core keeps running. While the core is halted or profiling is barred, that read returns all ones and the companions keep their old contents. Two read-only identification registers report which sample registers exist and how the sampled PC relates to the executing instruction. Both are set by parameters.

Top module: `pcs_dbg_unit`

## Requirements
- R1: After reset, bus_rvalid is 0, bus_rdata is 0, and the PC-high, context and virtual-context sample registers read as 0.
- R2: A read of offset 0x0A0 while the core is neither halted nor profiling-barred returns core_pc[31:0]. The value is in bus_rdata in the cycle after the read strobe, with bus_rvalid high.
- R3: That same read stores core_pc[63:32]. Later reads of offset 0x0AC return the stored value, whatever core_pc does meanwhile.
- R4: With SAMPLE_SET of 2 or more, that same read stores core_ctxid. Offset 0x0A4 returns it.
- R5: With SAMPLE_SET of 3, that same read stores a virtual-context word, returned at offset 0x0A8. The fields are: non-secure flag at bit 31, EL2 flag at bit 30, EL3 flag at bit 29, 64-bit-width flag at bit 28, VMID zero-extended in bits [7:0], and zeros in all other bits.
- R6: While core_halted or core_prof_block is high, a read of 0x0A0 returns 0xFFFFFFFF and leaves all three companion registers unchanged.
- R7: Sample registers that SAMPLE_SET does not implement read as 0 (context at 0x0A4 when SAMPLE_SET is below 2, virtual context at 0x0A8 when it is below 3).
- R8: Offset 0xFC8 returns SAMPLE_SET in bits [3:0] (1 means PC only, 2 means PC and context, 3 means all three). Offset 0xFC4 returns OFFSET_MODE in bits [3:0] (0 means the offset depends on instruction state, 1 means no offset, 2 means no offset and not usable in 32-bit state). The upper bits of both registers are 0.
- R9: Writes have no effect on any register. A cycle with both bus_rd and bus_wr high counts as a write: it does not raise bus_rvalid and does not capture.
- R10: A read of any offset other than the six listed returns 0.
- R11: The companion registers change only on a read of 0x0A0. Exactly one snapshot is taken per read.
- R12: bus_rvalid is high for exactly one cycle after each accepted read and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (discarded) |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| core_pc | input | 64 | Live program counter |
| core_ctxid | input | 32 | Live context identifier |
| core_vmid | input | VMID_W | Live virtual machine identifier |
| core_ns | input | 1 | Core in non-secure state |
| core_el2 | input | 1 | Core at EL2 |
| core_el3 | input | 1 | Core at EL3 |
| core_aa64 | input | 1 | Core executing in 64-bit width |
| core_halted | input | 1 | Core halted in debug state |
| core_prof_block | input | 1 | Sample-based profiling barred |

## Verification
The bench changes the core inputs between the capturing read and the companion reads. A design that forwarded live values instead of the snapshot would then return the new PC or context. Reads taken while the core is halted or profiling is barred must leave the older snapshot in place; a design that captured anyway would expose the newer values. Writes and combined read-write strobes aimed at the capture offset must leave the snapshot intact, and a second instance with the minimal sample set must read zeros where registers are absent. Each of these faults shows up as a mismatch against the cycle-by-cycle reference model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam logic [11:0] OFS_PC_LO  = 12'h0A0;
    localparam logic [11:0] OFS_CTX    = 12'h0A4;
    localparam logic [11:0] OFS_VCTX   = 12'h0A8;
    localparam logic [11:0] OFS_PC_HI  = 12'h0AC;
    localparam logic [11:0] OFS_ID_OFF = 12'hFC4;
    localparam logic [11:0] OFS_ID_SET = 12'hFC8;

    localparam int WORD_W = 32;
    localparam int PC_W   = 64;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PC_LO,
        SEL_CTX,
        SEL_VCTX,
        SEL_PC_HI,
        SEL_ID_OFF,
        SEL_ID_SET
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] pc_hi;
        logic [WORD_W-1:0] ctx;
        logic [WORD_W-1:0] vctx;
    } snap_t;

    function automatic logic [WORD_W-1:0] pack_vctx(
        input logic       ns,
        input logic       el2,
        input logic       el3,
        input logic       aa64,
        input logic [7:0] vmid
    );
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31]    = ns;
        w[30]    = el2;
        w[29]    = el3;
        w[28]    = aa64;
        w[7:0]   = vmid;
        return w;
    endfunction

endpackage

// File: rtl/pcs_addr_decode.sv
module pcs_addr_decode
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              rd_ok,
    output logic              capture
);

    always_comb begin
        sel = SEL_NONE;
        if      (addr == ADDR_W'(OFS_PC_LO))  sel = SEL_PC_LO;
        else if (addr == ADDR_W'(OFS_CTX))    sel = SEL_CTX;
        else if (addr == ADDR_W'(OFS_VCTX))   sel = SEL_VCTX;
        else if (addr == ADDR_W'(OFS_PC_HI))  sel = SEL_PC_HI;
        else if (addr == ADDR_W'(OFS_ID_OFF)) sel = SEL_ID_OFF;
        else if (addr == ADDR_W'(OFS_ID_SET)) sel = SEL_ID_SET;
    end

    // a strobe pair with write set is a write and is discarded
    assign rd_ok   = rd & ~wr;
    assign capture = rd_ok & (sel == SEL_PC_LO);

endmodule

// File: rtl/pcs_sample_regs.sv
module pcs_sample_regs
    import pcs_pkg::*;
#(
    parameter int SAMPLE_SET = 3,
    parameter int VMID_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              blocked,
    input  logic [PC_W-1:0]   core_pc,
    input  logic [WORD_W-1:0] core_ctxid,
    input  logic [VMID_W-1:0] core_vmid,
    input  logic              core_ns,
    input  logic              core_el2,
    input  logic              core_el3,
    input  logic              core_aa64,
    output snap_t             snap
);

    localparam bit HAS_CTX  = (SAMPLE_SET >= 2);
    localparam bit HAS_VCTX = (SAMPLE_SET >= 3);

    snap_t snap_d, snap_q;
    logic [WORD_W-1:0] ctx_live;
    logic [WORD_W-1:0] vctx_live;

    generate
        if (HAS_CTX) begin : g_ctx
            assign ctx_live = core_ctxid;
        end else begin : g_no_ctx
            assign ctx_live = '0;
        end
        if (HAS_VCTX) begin : g_vctx
            assign vctx_live = pack_vctx(core_ns, core_el2, core_el3, core_aa64,
                                         8'(core_vmid));
        end else begin : g_no_vctx
            assign vctx_live = '0;
        end
    endgenerate

    always_comb begin
        snap_d = snap_q;
        if (capture && !blocked) begin
            snap_d.pc_hi = core_pc[PC_W-1:WORD_W];
            snap_d.ctx   = ctx_live;
            snap_d.vctx  = vctx_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign snap = snap_q;

    // R11
    only_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap_q));

    // R6
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && blocked) |=> $stable(snap_q));

    // R3
    pc_hi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !blocked) |=> (snap_q.pc_hi == $past(core_pc[PC_W-1:WORD_W])));

    // R7
    absent_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_CTX) |-> (snap_q.ctx == '0));

    // R7
    absent_vctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_VCTX) |-> (snap_q.vctx == '0));

endmodule

// File: rtl/pcs_read_port.sv
module pcs_read_port
    import pcs_pkg::*;
#(
    parameter int SAMPLE_SET  = 3,
    parameter int OFFSET_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ok,
    input  reg_sel_e          sel,
    input  logic              blocked,
    input  logic [WORD_W-1:0] pc_lo,
    input  snap_t             snap,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    localparam logic [WORD_W-1:0] ID_SET_WORD = WORD_W'(4'(SAMPLE_SET));
    localparam logic [WORD_W-1:0] ID_OFF_WORD = WORD_W'(4'(OFFSET_MODE));

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
    } rp_state_t;

    rp_state_t st_d, st_q;
    logic [WORD_W-1:0] word_mux;

    always_comb begin
        unique case (sel)
            SEL_PC_LO:  word_mux = blocked ? '1 : pc_lo;
            SEL_CTX:    word_mux = snap.ctx;
            SEL_VCTX:   word_mux = snap.vctx;
            SEL_PC_HI:  word_mux = snap.pc_hi;
            SEL_ID_OFF: word_mux = ID_OFF_WORD;
            SEL_ID_SET: word_mux = ID_SET_WORD;
            default:    word_mux = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_ok;
        if (rd_ok) st_d.rdata = word_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

    // R12
    rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> rvalid);

    // R12
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> !rvalid);

    // R2
    pc_lo_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && sel == SEL_PC_LO && !blocked) |=> (rdata == $past(pc_lo)));

    // R6
    blocked_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && sel == SEL_PC_LO && blocked) |=> (rdata == '1));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && sel == SEL_NONE) |=> (rdata == '0));

endmodule

// File: rtl/pcs_dbg_unit.sv
module pcs_dbg_unit
    import pcs_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SAMPLE_SET  = 3,
    parameter int OFFSET_MODE = 0,
    parameter int VMID_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [63:0]       core_pc,
    input  logic [31:0]       core_ctxid,
    input  logic [VMID_W-1:0] core_vmid,
    input  logic              core_ns,
    input  logic              core_el2,
    input  logic              core_el3,
    input  logic              core_aa64,
    input  logic              core_halted,
    input  logic              core_prof_block
);

    reg_sel_e sel;
    logic     rd_ok;
    logic     capture;
    logic     blocked;
    snap_t    snap;
    logic     unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign blocked      = core_halted | core_prof_block;

    pcs_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .sel     (sel),
        .rd_ok   (rd_ok),
        .capture (capture)
    );

    pcs_sample_regs #(.SAMPLE_SET(SAMPLE_SET), .VMID_W(VMID_W)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .blocked    (blocked),
        .core_pc    (core_pc),
        .core_ctxid (core_ctxid),
        .core_vmid  (core_vmid),
        .core_ns    (core_ns),
        .core_el2   (core_el2),
        .core_el3   (core_el3),
        .core_aa64  (core_aa64),
        .snap       (snap)
    );

    pcs_read_port #(.SAMPLE_SET(SAMPLE_SET), .OFFSET_MODE(OFFSET_MODE)) u_rp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_ok   (rd_ok),
        .sel     (sel),
        .blocked (blocked),
        .pc_lo   (core_pc[31:0]),
        .snap    (snap),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

    // R9
    write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_rvalid);

endmodule

// File: tb/pcs_dbg_unit_tb.sv
`timescale 1ns/1ps
module pcs_dbg_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata1;
    logic        bus_rvalid, rvalid1;
    logic [63:0] core_pc = '0;
    logic [31:0] core_ctxid = '0;
    logic [7:0]  core_vmid = '0;
    logic        core_ns = 0, core_el2 = 0, core_el3 = 0, core_aa64 = 0;
    logic        core_halted = 0, core_prof_block = 0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pcs_dbg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .core_pc(core_pc), .core_ctxid(core_ctxid),
        .core_vmid(core_vmid), .core_ns(core_ns), .core_el2(core_el2),
        .core_el3(core_el3), .core_aa64(core_aa64), .core_halted(core_halted),
        .core_prof_block(core_prof_block)
    );

    pcs_dbg_unit #(.SAMPLE_SET(1), .OFFSET_MODE(2)) u_dut_min (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .bus_rvalid(rvalid1), .core_pc(core_pc), .core_ctxid(core_ctxid),
        .core_vmid(core_vmid), .core_ns(core_ns), .core_el2(core_el2),
        .core_el3(core_el3), .core_aa64(core_aa64), .core_halted(core_halted),
        .core_prof_block(core_prof_block)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // behavioural reference model of the default instance
    logic [31:0] m_hi = 0, m_ctx = 0, m_vctx = 0;
    logic [31:0] m_data = 0;
    logic        m_valid = 0;
    string       m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi <= 0; m_ctx <= 0; m_vctx <= 0; m_data <= 0; m_valid <= 0;
        end else begin
            m_valid <= bus_rd && !bus_wr;
            if (bus_rd && !bus_wr) begin
                case (bus_addr)
                    12'h0A0: begin
                        m_tag <= "R2/R6";
                        if (core_halted || core_prof_block) m_data <= 32'hFFFF_FFFF;
                        else begin
                            m_data <= core_pc[31:0];
                            m_hi   <= core_pc[63:32];
                            m_ctx  <= core_ctxid;
                            m_vctx <= (core_ns << 31) | (core_el2 << 30) |
                                      (core_el3 << 29) | (core_aa64 << 28) |
                                      32'(core_vmid);
                        end
                    end
                    12'h0A4: begin m_data <= m_ctx;  m_tag <= "R4"; end
                    12'h0A8: begin m_data <= m_vctx; m_tag <= "R5"; end
                    12'h0AC: begin m_data <= m_hi;   m_tag <= "R3"; end
                    12'hFC8: begin m_data <= 32'd3;  m_tag <= "R8"; end
                    12'hFC4: begin m_data <= 32'd0;  m_tag <= "R8"; end
                    default: begin m_data <= 32'd0;  m_tag <= "R10"; end
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(bus_rvalid == m_valid, "R12", 32'(bus_rvalid), 32'(m_valid));
            if (m_valid)
                chk(bus_rdata == m_data, m_tag, bus_rdata, m_data);
        end
    end

    // one read; returns data seen by both instances after the edge
    task automatic do_read(input logic [11:0] a, output logic [31:0] d0,
                           output logic [31:0] d1);
        bus_addr = a; bus_rd = 1; bus_wr = 0;
        @(negedge clk);
        bus_rd = 0;
        d0 = bus_rdata; d1 = rdata1;
    endtask

    task automatic read_exp(input logic [11:0] a, input logic [31:0] e,
                            input string req);
        logic [31:0] d0, d1;
        do_read(a, d0, d1);
        chk(d0 == e, req, d0, e);
    endtask

    task automatic read_exp_min(input logic [11:0] a, input logic [31:0] e,
                                input string req);
        logic [31:0] d0, d1;
        do_read(a, d0, d1);
        chk(d1 == e, req, d1, e);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input bit with_rd);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = with_rd;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        chk(bus_rvalid == 1'b0, "R9", 32'(bus_rvalid), 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_rvalid == 0, "R1", 32'(bus_rvalid), 0);
        chk(bus_rdata == 0, "R1", bus_rdata, 0);
        rst_n = 1;
        @(negedge clk);
        read_exp(12'h0AC, 32'h0, "R1");
        read_exp(12'h0A4, 32'h0, "R1");
        read_exp(12'h0A8, 32'h0, "R1");

        core_pc = 64'h0123_4567_89AB_CDEF; core_ctxid = 32'hCAFE_0001;
        core_vmid = 8'h5A; core_ns = 1; core_el2 = 0; core_el3 = 1; core_aa64 = 1;
        read_exp(12'h0A0, 32'h89AB_CDEF, "R2");
        core_pc = 64'hDEAD_BEEF_0000_1111; core_ctxid = 32'h1; core_vmid = 8'h00;
        core_ns = 0; core_el3 = 0; core_aa64 = 0;
        read_exp(12'h0AC, 32'h0123_4567, "R3");
        read_exp(12'h0A4, 32'hCAFE_0001, "R4");
        read_exp(12'h0A8, 32'hB000_005A, "R5");

        core_halted = 1;
        read_exp(12'h0A0, 32'hFFFF_FFFF, "R6");
        core_halted = 0; core_prof_block = 1;
        read_exp(12'h0A0, 32'hFFFF_FFFF, "R6");
        core_prof_block = 0;
        read_exp(12'h0AC, 32'h0123_4567, "R6");
        read_exp(12'h0A4, 32'hCAFE_0001, "R6");

        core_pc = 64'h7777_0000_2222_0001;
        repeat (4) @(negedge clk);
        read_exp(12'h0AC, 32'h0123_4567, "R11");

        do_write(12'h0AC, 32'h5555_5555, 0);
        do_write(12'h0A0, 32'h6666_6666, 0);
        do_write(12'h0A0, 32'h7777_7777, 1);
        read_exp(12'h0AC, 32'h0123_4567, "R9");
        read_exp(12'h0A8, 32'hB000_005A, "R9");
        do_write(12'hFC8, 32'hFFFF_FFFF, 0);
        read_exp(12'hFC8, 32'd3, "R8");
        read_exp(12'hFC4, 32'd0, "R8");

        read_exp(12'h000, 32'h0, "R10");
        read_exp(12'h0B0, 32'h0, "R10");
        read_exp(12'hFFC, 32'h0, "R10");

        core_el2 = 1; core_ns = 0; core_aa64 = 0; core_vmid = 8'hC3;
        core_ctxid = 32'h0BAD_F00D;
        read_exp(12'h0A0, 32'h2222_0001, "R2");
        read_exp(12'h0A8, 32'h4000_00C3, "R5");
        read_exp(12'h0AC, 32'h7777_0000, "R3");
        read_exp(12'h0A4, 32'h0BAD_F00D, "R4");

        read_exp_min(12'h0A4, 32'h0, "R7");
        read_exp_min(12'h0A8, 32'h0, "R7");
        read_exp_min(12'h0AC, 32'h7777_0000, "R3");
        read_exp_min(12'hFC8, 32'd1, "R8");
        read_exp_min(12'hFC4, 32'd2, "R8");

        bus_addr = 12'h0A4; bus_rd = 1;
        @(negedge clk);
        chk(bus_rvalid == 1, "R12", 32'(bus_rvalid), 1);
        @(negedge clk);
        chk(bus_rvalid == 1, "R12", 32'(bus_rvalid), 1);
        bus_rd = 0;
        @(negedge clk);
        chk(bus_rvalid == 0, "R12", 32'(bus_rvalid), 0);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

endmodule